// File: doc/BRIEF.md
# Carrier Recovery Phase-Locked Loop Core

This block closes the feedback path of a sample-by-sample digital phase-locked loop that pulls a local oscillator onto an unmodulated carrier. For each accepted input sample it forms two mixing products: the sample times the oscillator cosine, and the sample times the oscillator sine. Each product runs through its own one-pole low-pass stage, which suppresses the term at twice the carrier frequency. The phase error is the filtered quadrature value with its sign inverted. That error is smoothed by a one-pole loop filter with unity DC gain and scaled by a loop gain.

The result is a signed phase-offset word. A separate numerically controlled oscillator adds this word to its phase recursion, so that phase[n] = phase[n-1] + nominal step + offset[n]. The oscillator's cosine and sine are fed back into the block with the next sample. The filtered in-phase and quadrature values are also brought out, aligned with the offset word, so that lock can be judged. When the loop is locked, the quadrature value settles near zero and the in-phase value settles near half the input amplitude.

The loop-filter coefficient and the loop gain are run-time inputs. Their typical values are 0.6 and 0.15.

Top module: `cr_pll_loop`

## Requirements
- R1: While reset is asserted and right after it, out_valid is 0 and phase_ofs, lock_i and lock_q are 0. The first sample after reset is processed from all-zero filter and loop state.
- R2: All values are signed Q1.15. Each mixing product is rounded as rnd(p) = (p + 16384) >>> 15 and saturated to [-32768, 32767]. The products are mix_i = rnd(x*cos) and mix_q = rnd(x*sin).
- R3: Each branch keeps a low-pass state s that updates as s = sat(s + ((mix - s) >>> LPF_SHIFT)). The shift is arithmetic (floor), and LPF_SHIFT defaults to 2.
- R4: The phase error is the negated filtered quadrature value, saturated: e = sat(-s_q).
- R5: The loop filter state is y = sat(rnd(beta*e) + rnd(alpha*y_prev)), with beta = 32768 - alpha and alpha in [0, 32767]. With alpha = 0, y equals e.
- R6: The output word is phase_ofs = rnd(gain*y), with gain a signed Q1.15 input.
- R7: out_valid is high in exactly the fourth clock cycle after a cycle in which in_valid is high, once per sample. A new sample is accepted on every cycle.
- R8: Cycles with in_valid low change no state, and phase_ofs, lock_i and lock_q hold their values.
- R9: lock_i and lock_q show the filtered in-phase and quadrature states after the same sample whose phase_ofs is presented.
- R10: The loop is closed through an oscillator that adds phase_ofs*pi/32768 radians per sample to a nominal step of pi/2. With alpha = 19661, gain = 4915, LPF_SHIFT = 2 and a carrier at pi/2 + pi/1024 with amplitude 0.5, the loop locks. Once locked, lock_q averages near 0, lock_i averages near 8192, and phase_ofs averages near 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A new sample and oscillator pair is present this cycle |
| in_sample | input | 16 | Received sample, signed Q1.15 |
| nco_cos | input | 16 | Oscillator cosine, signed Q1.15 |
| nco_sin | input | 16 | Oscillator sine, signed Q1.15 |
| alpha_q15 | input | 16 | Loop-filter pole coefficient, Q1.15, 0 to 32767 |
| gain_q15 | input | 16 | Loop gain, signed Q1.15 |
| out_valid | output | 1 | phase_ofs, lock_i and lock_q belong to a new sample |
| phase_ofs | output | 16 | Signed phase-offset word for the oscillator |
| lock_i | output | 16 | Filtered in-phase value |
| lock_q | output | 16 | Filtered quadrature value |

## Verification
The loop is tried with four kinds of input, each checked word for word against a bench model of the fixed-point arithmetic:
- Open-loop random samples with random coefficients, sent both back to back and with gaps. These separate errors in rounding, saturation and shift direction, and expose pipeline stages that advance on the wrong sample.
- Directed full-scale negative operands. These hit product saturation.
- A zero pole coefficient. This isolates the loop filter from its memory.
- An idle stretch followed by a single sample, and a reset in the middle of a run. These show whether idle cycles or reset leave stray state behind.

Finally, the loop is closed through a modelled oscillator against a carrier offset by pi/1024. Averaged outputs then tell a locked loop from one that slips cycles or settles on the wrong sign.

// File: rtl/cr_pkg.sv
`timescale 1ns/1ps
package cr_pkg;
  localparam int unsigned CR_DW = 16;
  localparam int unsigned CR_FB = CR_DW - 1;
  localparam int unsigned CR_PW = 2 * CR_DW + 2;
  localparam int unsigned CR_BR = 2;

  typedef logic signed [CR_DW-1:0] smp_t;
  typedef logic signed [CR_PW-1:0] wide_t;

  typedef struct packed {
    smp_t i;
    smp_t q;
  } iq_t;

  localparam wide_t SMP_MAX = (wide_t'(1) <<< CR_FB) - wide_t'(1);
  localparam wide_t SMP_MIN = -(wide_t'(1) <<< CR_FB);

  function automatic wide_t wx(input smp_t a);
    return wide_t'(a);
  endfunction

  function automatic smp_t sat(input wide_t v);
    if (v > SMP_MAX) return smp_t'(SMP_MAX);
    if (v < SMP_MIN) return smp_t'(SMP_MIN);
    return smp_t'(v);
  endfunction

  function automatic smp_t rnd_mul(input wide_t p);
    wide_t r;
    r = (p + (wide_t'(1) <<< (CR_FB - 1))) >>> CR_FB;
    return sat(r);
  endfunction
endpackage

// File: rtl/cr_mixer.sv
`timescale 1ns/1ps
module cr_mixer
  import cr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  smp_t x,
  input  smp_t lo_cos,
  input  smp_t lo_sin,
  output iq_t  mix
);
  iq_t mix_d, mix_q;

  always_comb begin
    mix_d.i = rnd_mul(wx(x) * wx(lo_cos));
    mix_d.q = rnd_mul(wx(x) * wx(lo_sin));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mix_q <= '0;
    end else if (en) begin
      mix_q <= mix_d;
    end
  end

  assign mix = mix_q;
endmodule

// File: rtl/cr_lowpass.sv
`timescale 1ns/1ps
module cr_lowpass
  import cr_pkg::*;
#(
  parameter int unsigned SHIFT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  smp_t x,
  output smp_t y
);
  smp_t  st_d, st_q;
  wide_t diff;

  always_comb begin
    diff = wx(x) - wx(st_q);
    st_d = sat(wx(st_q) + (diff >>> SHIFT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (en) begin
      st_q <= st_d;
    end
  end

  assign y = st_q;
endmodule

// File: rtl/cr_loop_filter.sv
`timescale 1ns/1ps
module cr_loop_filter
  import cr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  smp_t err,
  input  smp_t alpha,
  output smp_t y
);
  wide_t beta;
  smp_t  fwd_term, fb_term;
  smp_t  y_d, y_q;

  always_comb begin
    beta     = (wide_t'(1) <<< CR_FB) - wx(alpha);
    fwd_term = rnd_mul(beta * wx(err));
    fb_term  = rnd_mul(wx(alpha) * wx(y_q));
    y_d      = sat(wx(fwd_term) + wx(fb_term));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
    end else if (en) begin
      y_q <= y_d;
    end
  end

  assign y = y_q;
endmodule

// File: rtl/cr_gain_stage.sv
`timescale 1ns/1ps
module cr_gain_stage
  import cr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  smp_t y,
  input  smp_t gain,
  output smp_t ofs
);
  smp_t ofs_d, ofs_q;

  always_comb begin
    ofs_d = rnd_mul(wx(gain) * wx(y));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else if (en) begin
      ofs_q <= ofs_d;
    end
  end

  assign ofs = ofs_q;
endmodule

// File: rtl/cr_pll_loop.sv
`timescale 1ns/1ps
module cr_pll_loop
  import cr_pkg::*;
#(
  parameter int unsigned LPF_SHIFT = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [CR_DW-1:0] in_sample,
  input  logic signed [CR_DW-1:0] nco_cos,
  input  logic signed [CR_DW-1:0] nco_sin,
  input  logic signed [CR_DW-1:0] alpha_q15,
  input  logic signed [CR_DW-1:0] gain_q15,
  output logic                    out_valid,
  output logic signed [CR_DW-1:0] phase_ofs,
  output logic signed [CR_DW-1:0] lock_i,
  output logic signed [CR_DW-1:0] lock_q
);
  localparam int unsigned PIPE_LAT = 4;
  localparam int unsigned SYNC_LEN = 2;

  // reset: asserted at once, released after SYNC_LEN clocks
  logic [SYNC_LEN-1:0] rsync_q;
  logic                rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[SYNC_LEN-2:0], 1'b1};
    end
  end

  assign rst_q = rsync_q[SYNC_LEN-1];

  // one valid bit per stage: mix, low-pass, loop filter, gain
  logic [PIPE_LAT-1:0] vpipe_d, vpipe_q;

  always_comb begin
    vpipe_d = {vpipe_q[PIPE_LAT-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vpipe_q <= '0;
    end else begin
      vpipe_q <= vpipe_d;
    end
  end

  // stage 1: mixing
  iq_t mix;

  cr_mixer i_mixer (
    .clk    (clk),
    .rst_n  (rst_q),
    .en     (in_valid),
    .x      (in_sample),
    .lo_cos (nco_cos),
    .lo_sin (nco_sin),
    .mix    (mix)
  );

  // stage 2: one low-pass per branch (0 = in-phase, 1 = quadrature)
  smp_t mix_br [CR_BR];
  smp_t lpf_br [CR_BR];

  assign mix_br[0] = mix.i;
  assign mix_br[1] = mix.q;

  for (genvar b = 0; b < CR_BR; b++) begin : g_branch
    cr_lowpass #(
      .SHIFT (LPF_SHIFT)
    ) i_lpf (
      .clk   (clk),
      .rst_n (rst_q),
      .en    (vpipe_q[0]),
      .x     (mix_br[b]),
      .y     (lpf_br[b])
    );
  end

  // stage 3: phase detection and loop filter
  smp_t err_c;
  smp_t loop_y;

  always_comb begin
    err_c = sat(-wx(lpf_br[1]));
  end

  cr_loop_filter i_loop (
    .clk   (clk),
    .rst_n (rst_q),
    .en    (vpipe_q[1]),
    .err   (err_c),
    .alpha (alpha_q15),
    .y     (loop_y)
  );

  // stage 4: loop gain
  cr_gain_stage i_gain (
    .clk   (clk),
    .rst_n (rst_q),
    .en    (vpipe_q[2]),
    .y     (loop_y),
    .gain  (gain_q15),
    .ofs   (phase_ofs)
  );

  // filtered branch values carried along with their sample
  iq_t al3_d, al3_q, al4_q;

  always_comb begin
    al3_d.i = lpf_br[0];
    al3_d.q = lpf_br[1];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      al3_q <= '0;
    end else if (vpipe_q[1]) begin
      al3_q <= al3_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      al4_q <= '0;
    end else if (vpipe_q[2]) begin
      al4_q <= al3_q;
    end
  end

  assign lock_i    = al4_q.i;
  assign lock_q    = al4_q.q;
  assign out_valid = vpipe_q[PIPE_LAT-1];
endmodule

// File: rtl/cr_pll_loop_chk.sv
`timescale 1ns/1ps
module cr_pll_loop_chk
  import cr_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic out_valid,
  input smp_t phase_ofs,
  input logic en_loop,
  input logic en_gain,
  input smp_t alpha,
  input smp_t err,
  input smp_t loop_y,
  input smp_t filt_q
);
  logic [LAT-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= {hist_q[LAT-2:0], in_valid};
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && phase_ofs == '0));

  assert_err_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q > 0 |-> err < 0) and (filt_q < 0 |-> err > 0));

  assert_alpha_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_loop && alpha == '0) |=> (loop_y == $past(err)));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == hist_q[LAT-1]);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_gain |=> $stable(phase_ofs));
endmodule

bind cr_pll_loop cr_pll_loop_chk #(.LAT(4)) i_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .phase_ofs (phase_ofs),
  .en_loop   (vpipe_q[1]),
  .en_gain   (vpipe_q[2]),
  .alpha     (alpha_q15),
  .err       (err_c),
  .loop_y    (loop_y),
  .filt_q    (lpf_br[1])
);

// File: tb/test_cr_pll_loop.sv
`timescale 1ns/1ps
module test_cr_pll_loop;
  localparam int SH = 2;
  localparam real PI = 3.14159265358979;

  logic clk;
  logic rst_n;
  logic in_valid;
  logic signed [15:0] in_sample, nco_cos, nco_sin, alpha_q15, gain_q15;
  logic out_valid;
  logic signed [15:0] phase_ofs, lock_i, lock_q;

  cr_pll_loop #(.LPF_SHIFT(SH)) i_cr_pll_loop (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .nco_cos(nco_cos), .nco_sin(nco_sin), .alpha_q15(alpha_q15),
    .gain_q15(gain_q15), .out_valid(out_valid), .phase_ofs(phase_ofs),
    .lock_i(lock_i), .lock_q(lock_q)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;
  int m_si, m_sq, m_y, cur_a, cur_k;
  string cur_tag;
  int q_d[$], q_i[$], q_q[$], q_c[$];
  string q_t[$];
  int last_d, last_i, last_q;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act %0d exp %0d", tag, what, act, exp);
    end
  endtask

  function automatic int m_sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int m_rnd(longint p);
    return m_sat((p + 64'sd16384) >>> 15);
  endfunction

  function automatic int m_lpf(int s, int m);
    return m_sat(longint'(s) + ((longint'(m) - longint'(s)) >>> SH));
  endfunction

  task automatic drive(int x, int c, int s);
    int mi, mq, e;
    mi = m_rnd(longint'(x) * longint'(c));
    mq = m_rnd(longint'(x) * longint'(s));
    m_si = m_lpf(m_si, mi);
    m_sq = m_lpf(m_sq, mq);
    e = m_sat(-longint'(m_sq));
    m_y = m_sat(longint'(m_rnd(longint'(32768 - cur_a) * e)) +
                longint'(m_rnd(longint'(cur_a) * m_y)));
    q_d.push_back(m_rnd(longint'(cur_k) * m_y));
    q_i.push_back(m_si);
    q_q.push_back(m_sq);
    q_c.push_back(cyc);
    q_t.push_back(cur_tag);
    in_sample = 16'(x);
    nco_cos = 16'(c);
    nco_sin = 16'(s);
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (q_d.size() != 0) @(negedge clk);
  endtask

  task automatic set_coef(int a, int k);
    cur_a = a;
    cur_k = k;
    alpha_q15 = 16'(a);
    gain_q15 = 16'(k);
  endtask

  function automatic int rnd16();
    return int'($urandom_range(65535, 0)) - 32768;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // monitor: compare every presented result against the model
  always @(negedge clk) begin
    if (!done && out_valid) begin
      if (q_d.size() == 0) begin
        check(1'b0, "R7", "unexpected out_valid", 1, 0);
      end else begin
        check(int'(phase_ofs) == q_d[0], q_t[0], "phase_ofs R6", int'(phase_ofs), q_d[0]);
        check(int'(lock_i) == q_i[0], "R9", "lock_i", int'(lock_i), q_i[0]);
        check(int'(lock_q) == q_q[0], "R9", "lock_q", int'(lock_q), q_q[0]);
        check(cyc - q_c[0] == 4, "R7", "latency", cyc - q_c[0], 4);
        last_d = int'(phase_ofs);
        last_i = int'(lock_i);
        last_q = int'(lock_q);
        void'(q_d.pop_front());
        void'(q_i.pop_front());
        void'(q_q.pop_front());
        void'(q_c.pop_front());
        void'(q_t.pop_front());
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (!done && cyc > 190000) begin
      check(1'b0, "WD", "watchdog expired", cyc, 190000);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sample = '0;
    nco_cos = '0;
    nco_sin = '0;
    set_coef(19661, 4915);
    m_si = 0; m_sq = 0; m_y = 0;
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(phase_ofs == 0, "R1", "phase_ofs in reset", int'(phase_ofs), 0);
    check(lock_i == 0, "R1", "lock_i in reset", int'(lock_i), 0);
    check(lock_q == 0, "R1", "lock_q in reset", int'(lock_q), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    // R2: full-scale negative operands saturate the product
    set_coef(0, 32767);
    cur_tag = "R2";
    drive(-32768, -32768, -32768);
    drive(-32768, -32768, -32768);
    drain();

    // R5: zero pole passes the error straight through; R4 sign
    cur_tag = "R4 R5";
    for (int n = 0; n < 12; n++) drive(rnd16(), rnd16(), rnd16());
    drain();

    // R2 R3 R5 R6: random groups, back to back and with gaps (R7)
    for (int g = 0; g < 8; g++) begin
      set_coef(int'($urandom_range(32767, 0)), rnd16());
      cur_tag = "R2 R3 R5 R6";
      for (int n = 0; n < 40; n++) begin
        drive(rnd16(), rnd16(), rnd16());
        if ($urandom_range(3, 0) == 0) begin
          in_valid = 1'b0;
          repeat (int'($urandom_range(3, 1))) @(negedge clk);
        end
      end
      drain();
    end

    // R8: idle cycles leave outputs and state untouched
    begin
      int hd, hi, hq;
      hd = int'(phase_ofs); hi = int'(lock_i); hq = int'(lock_q);
      repeat (20) @(negedge clk);
      check(int'(phase_ofs) == hd, "R8", "phase_ofs held", int'(phase_ofs), hd);
      check(int'(lock_i) == hi, "R8", "lock_i held", int'(lock_i), hi);
      check(int'(lock_q) == hq, "R8", "lock_q held", int'(lock_q), hq);
      cur_tag = "R8";
      drive(rnd16(), rnd16(), rnd16());
      drain();
    end

    // R1: reset in mid-run clears state
    rst_n = 1'b0;
    @(negedge clk);
    check(phase_ofs == 0, "R1", "phase_ofs after mid reset", int'(phase_ofs), 0);
    check(lock_i == 0, "R1", "lock_i after mid reset", int'(lock_i), 0);
    check(lock_q == 0, "R1", "lock_q after mid reset", int'(lock_q), 0);
    rst_n = 1'b1;
    m_si = 0; m_sq = 0; m_y = 0;
    repeat (4) @(negedge clk);
    cur_tag = "R1";
    drive(20000, 12000, -9000);
    drain();

    // R10: closed loop against an offset carrier
    set_coef(19661, 4915);
    m_si = 0; m_sq = 0; m_y = 0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_tag = "R10";
    begin
      real ph_rx, ph_lo, w0, sum_i, sum_q, sum_d;
      ph_rx = 1.0; ph_lo = 0.0; w0 = PI / 2.0;
      sum_i = 0.0; sum_q = 0.0; sum_d = 0.0;
      for (int n = 0; n < 3000; n++) begin
        drive(int'(0.5 * $cos(ph_rx) * 32767.0), int'($cos(ph_lo) * 32767.0),
              int'($sin(ph_lo) * 32767.0));
        drain();
        ph_lo = ph_lo + w0 + real'(last_d) * PI / 32768.0;
        ph_rx = ph_rx + w0 + PI / 1024.0;
        if (ph_lo >= 2.0 * PI) ph_lo = ph_lo - 2.0 * PI;
        if (ph_lo < 0.0) ph_lo = ph_lo + 2.0 * PI;
        if (ph_rx >= 2.0 * PI) ph_rx = ph_rx - 2.0 * PI;
        if (n >= 2744) begin
          sum_i = sum_i + real'(last_i);
          sum_q = sum_q + real'(last_q);
          sum_d = sum_d + real'(last_d);
        end
      end
      sum_i = sum_i / 256.0; sum_q = sum_q / 256.0; sum_d = sum_d / 256.0;
      check(sum_q < 600.0 && sum_q > -600.0, "R10", "mean lock_q", int'(sum_q), 0);
      check(sum_i > 7400.0 && sum_i < 9000.0, "R10", "mean lock_i", int'(sum_i), 8192);
      check(sum_d > 20.0 && sum_d < 44.0, "R10", "mean phase_ofs", int'(sum_d), 32);
    end

    finish_run();
  end
endmodule